// File: doc/BRIEF.md
# Carry-Save Modular Exponentiation Sequencer

This block raises a base to an exponent modulo an odd modulus. It uses a right-to-left binary method. Every intermediate value stays in redundant form: the running product, the squaring chain and every multiplier output are held as two vectors whose sum is the value. A bit-serial Montgomery multiplier reduces five addends to two on each step. It consumes one bit of its first operand per cycle, and that bit is produced by a small serial adder over the operand pair. The only full-width carry-propagate addition happens once, at the end. A single conditional subtraction of the modulus follows it.

The caller supplies the base, the exponent, the modulus and the Montgomery square constant `mont_k = 2^(2(W+2)) mod modulus`. The block does not compute this constant. The caller pulses `start` while the block is free, and the operands are captured on that edge. The block then runs its states in this order:

- `ST_INIT_P`: Montgomery product of (K,0) and (1,0), which becomes the accumulator pair.
- `ST_INIT_Z`: product of (K,0) and (base,0), which becomes the squaring pair.
- Per exponent bit, lowest bit first:
  - `ST_MUL`: entered only when the bit is 1. The accumulator pair is multiplied by the current squaring pair.
  - `ST_SQR`: the squaring pair is multiplied by itself.
- `ST_EXIT`: the accumulator pair is multiplied by (1,0).
- `ST_MERGE`: the two vectors are added and the result is corrected once.
- `ST_DONE`: the result is held.

The transitions are:

- `ST_IDLE`/`ST_DONE` to `ST_INIT_P` on an accepted start.
- `ST_INIT_P` to `ST_INIT_Z`.
- `ST_INIT_Z` to `ST_MUL` or `ST_SQR`, depending on exponent bit 0.
- `ST_MUL` to `ST_SQR`.
- `ST_SQR` to `ST_MUL` or `ST_SQR` on the next bit, or to `ST_EXIT` after the last bit.
- `ST_EXIT` to `ST_MERGE`.
- `ST_MERGE` to `ST_DONE`.

The multiply always runs before the square within an iteration, so it sees the squaring pair from before that iteration.

Top module: `modexp_csa_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `result` is 0.
- R2: A `start` pulse while the block is idle or done is accepted. From the next cycle `busy` is 1 and `done` is 0.
- R3: For an odd `modulus` in [3, 2^W), `base` < `modulus` and `mont_k` = 2^(2(W+2)) mod `modulus`, `result` equals `base`^`expo` mod `modulus` when `done` is 1.
- R4: With `expo` = 0 the result is 1.
- R5: With `expo` = 1 the result equals `base`, including `base` = 0.
- R6: A `start` pulse while `busy` is 1 is ignored. The operation in flight continues with its captured operands and produces their result.
- R7: `result` is always in the range 0 to `modulus`-1 while `done` is 1.
- R8: `done` stays 1 and `result` stays unchanged until the next accepted `start`.
- R9: All EXP_W exponent bits are scanned, bit 0 first. Exponents with the top bit set, or with all bits set, give correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation; operands are sampled on this edge |
| base | input | W | Base value, below the modulus |
| expo | input | EXP_W | Exponent |
| modulus | input | W | Odd modulus |
| mont_k | input | W | 2^(2(W+2)) mod modulus |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid |
| result | output | W | Final residue |

## Verification
Several properties are checked on every cycle:

- `busy` and `done` are never high together.
- Captured operands do not move when `start` arrives during a run.
- Each carry-save step leaves an even total, so halving is exact.
- Every multiplier result pair sums to less than twice the modulus.
- The held result is below the modulus and does not change while `done` stays high.

Only the scenarios can show that the number itself is right. These include:

- random odd moduli against a behavioural reference;
- exponents 0, 1 and all ones;
- a zero base;
- the smallest modulus;
- an ignored start that must not disturb the running result.

// File: rtl/modexp_pkg.sv
package modexp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT_P,
        ST_INIT_Z,
        ST_MUL,
        ST_SQR,
        ST_EXIT,
        ST_MERGE,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/csa_row.sv
module csa_row #(
    parameter int VW = 67
) (
    input  logic [VW-1:0] x,
    input  logic [VW-1:0] y,
    input  logic [VW-1:0] z,
    output logic [VW-1:0] sum,
    output logic [VW-1:0] carry
);
    logic [VW-1:0] maj;

    assign sum   = x ^ y ^ z;
    assign maj   = (x & y) | (x & z) | (y & z);
    // carry vector is weighted one place up; its bit 0 is always zero
    assign carry = {maj[VW-2:0], 1'b0};
endmodule

// File: rtl/mm_csa.sv
module mm_csa #(
    parameter int W    = 64,
    parameter int VW   = W + 3,
    parameter int ITER = W + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [VW-1:0] a1,
    input  logic [VW-1:0] a2,
    input  logic [VW-1:0] b1,
    input  logic [VW-1:0] b2,
    input  logic [W-1:0]  m,
    output logic [VW-1:0] r1,
    output logic [VW-1:0] r2,
    output logic          rdy
);
    localparam int CW = $clog2(ITER + 1);
    localparam int NSTAGE = 3;

    logic [VW-1:0] a1_q, a2_q, b1_q, b2_q, s1_q, s2_q;
    logic          cy_q, run_q, rdy_q;
    logic [CW-1:0] cnt_q;

    logic          ai, cy_n, qbit;
    logic [VW-1:0] m_ext;
    logic [VW-1:0] addend [0:NSTAGE-1];
    logic [VW-1:0] lvl_s  [0:NSTAGE];
    logic [VW-1:0] lvl_c  [0:NSTAGE];

    assign m_ext = {{(VW-W){1'b0}}, m};

    // serial adder yields one bit of (a1 + a2) per cycle
    assign ai   = a1_q[0] ^ a2_q[0] ^ cy_q;
    assign cy_n = (a1_q[0] & a2_q[0]) | (a1_q[0] & cy_q) | (a2_q[0] & cy_q);
    // reduction bit chosen so that the five-term total is even
    assign qbit = s1_q[0] ^ s2_q[0] ^ (ai & (b1_q[0] ^ b2_q[0]));

    always_comb begin
        addend[0] = ai   ? b1_q  : '0;
        addend[1] = ai   ? b2_q  : '0;
        addend[2] = qbit ? m_ext : '0;
    end

    assign lvl_s[0] = s1_q;
    assign lvl_c[0] = s2_q;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_tree
        csa_row #(.VW(VW)) u_row (
            .x     (lvl_s[g]),
            .y     (lvl_c[g]),
            .z     (addend[g]),
            .sum   (lvl_s[g+1]),
            .carry (lvl_c[g+1])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a1_q  <= '0;
            a2_q  <= '0;
            b1_q  <= '0;
            b2_q  <= '0;
            s1_q  <= '0;
            s2_q  <= '0;
            cy_q  <= 1'b0;
            cnt_q <= '0;
            run_q <= 1'b0;
            rdy_q <= 1'b0;
        end else if (go && !run_q) begin
            a1_q  <= a1;
            a2_q  <= a2;
            b1_q  <= b1;
            b2_q  <= b2;
            s1_q  <= '0;
            s2_q  <= '0;
            cy_q  <= 1'b0;
            cnt_q <= '0;
            run_q <= 1'b1;
            rdy_q <= 1'b0;
        end else if (run_q) begin
            a1_q  <= a1_q >> 1;
            a2_q  <= a2_q >> 1;
            cy_q  <= cy_n;
            s1_q  <= lvl_s[NSTAGE] >> 1;
            s2_q  <= lvl_c[NSTAGE] >> 1;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(ITER - 1)) begin
                run_q <= 1'b0;
                rdy_q <= 1'b1;
            end
        end else begin
            rdy_q <= 1'b0;
        end
    end

    assign r1  = s1_q;
    assign r2  = s2_q;
    assign rdy = rdy_q;

    // R3: the chosen reduction bit must make the halving exact
    p_even_total_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (lvl_s[NSTAGE][0] == 1'b0));

    // R3: each product pair stays below twice the modulus
    p_pair_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_q |-> (({1'b0, s1_q} + {1'b0, s2_q}) < {m_ext, 1'b0}));

    // R6: a new product is never launched over a running one
    p_no_relaunch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> !go);
endmodule

// File: rtl/final_merge.sv
module final_merge #(
    parameter int W  = 64,
    parameter int VW = W + 3
) (
    input  logic [VW-1:0] r1,
    input  logic [VW-1:0] r2,
    input  logic [W-1:0]  m,
    output logic [W-1:0]  res
);
    logic [VW:0] total;
    logic [VW:0] m_ext;

    assign m_ext = {{(VW+1-W){1'b0}}, m};
    assign total = {1'b0, r1} + {1'b0, r2};

    // a single corrective subtraction brings the sum into [0, m-1]
    always_comb begin
        if (total >= m_ext) res = W'(total - m_ext);
        else                res = W'(total);
    end
endmodule

// File: rtl/modexp_csa_seq.sv
module modexp_csa_seq
    import modexp_pkg::*;
#(
    parameter int W     = 64,
    parameter int EXP_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     base,
    input  logic [EXP_W-1:0] expo,
    input  logic [W-1:0]     modulus,
    input  logic [W-1:0]     mont_k,
    output logic             busy,
    output logic             done,
    output logic [W-1:0]     result
);
    localparam int VW   = W + 3;
    localparam int ITER = W + 2;
    localparam int IW   = $clog2(EXP_W + 1);

    seq_state_t state_q, state_d;

    logic             waiting_q;
    logic [W-1:0]     m_q, base_q, k_q, result_q;
    logic [EXP_W-1:0] e_q;
    logic [IW-1:0]    idx_q;
    logic [VW-1:0]    p1_q, p2_q, z1_q, z2_q;

    logic             op_state, go, mm_rdy, accept;
    logic [VW-1:0]    a1, a2, b1, b2, r1, r2;
    logic [W-1:0]     merged;
    logic             last_bit;

    assign accept   = start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign op_state = (state_q == ST_INIT_P) || (state_q == ST_INIT_Z) ||
                      (state_q == ST_MUL)    || (state_q == ST_SQR)    ||
                      (state_q == ST_EXIT);
    assign go       = op_state && !waiting_q;
    assign last_bit = (idx_q == IW'(EXP_W - 1));

    // operand selection per state
    always_comb begin
        a1 = '0;
        a2 = '0;
        b1 = '0;
        b2 = '0;
        unique case (state_q)
            ST_INIT_P: begin
                a1 = VW'(k_q);
                b1 = VW'(1);
            end
            ST_INIT_Z: begin
                a1 = VW'(k_q);
                b1 = VW'(base_q);
            end
            ST_MUL: begin
                a1 = p1_q; a2 = p2_q;
                b1 = z1_q; b2 = z2_q;
            end
            ST_SQR: begin
                a1 = z1_q; a2 = z2_q;
                b1 = z1_q; b2 = z2_q;
            end
            ST_EXIT: begin
                a1 = VW'(1);
                b1 = p1_q; b2 = p2_q;
            end
            default: ;
        endcase
    end

    mm_csa #(.W(W), .VW(VW), .ITER(ITER)) u_mm (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .a1    (a1),
        .a2    (a2),
        .b1    (b1),
        .b2    (b2),
        .m     (m_q),
        .r1    (r1),
        .r2    (r2),
        .rdy   (mm_rdy)
    );

    final_merge #(.W(W), .VW(VW)) u_merge (
        .r1  (p1_q),
        .r2  (p2_q),
        .m   (m_q),
        .res (merged)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: if (start) state_d = ST_INIT_P;
            ST_INIT_P:        if (mm_rdy) state_d = ST_INIT_Z;
            ST_INIT_Z:        if (mm_rdy) state_d = e_q[0] ? ST_MUL : ST_SQR;
            ST_MUL:           if (mm_rdy) state_d = ST_SQR;
            ST_SQR: begin
                if (mm_rdy) begin
                    if (last_bit)    state_d = ST_EXIT;
                    else if (e_q[1]) state_d = ST_MUL;
                    else             state_d = ST_SQR;
                end
            end
            ST_EXIT:          if (mm_rdy) state_d = ST_MERGE;
            ST_MERGE:         state_d = ST_DONE;
            default:          state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            waiting_q <= 1'b0;
            m_q       <= '0;
            base_q    <= '0;
            k_q       <= '0;
            e_q       <= '0;
            idx_q     <= '0;
            p1_q      <= '0;
            p2_q      <= '0;
            z1_q      <= '0;
            z2_q      <= '0;
            result_q  <= '0;
        end else begin
            if (go)          waiting_q <= 1'b1;
            else if (mm_rdy) waiting_q <= 1'b0;
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (accept) begin
                        m_q    <= modulus;
                        base_q <= base;
                        k_q    <= mont_k;
                        e_q    <= expo;
                        idx_q  <= '0;
                    end
                end
                ST_INIT_P, ST_MUL, ST_EXIT: begin
                    if (mm_rdy) begin
                        p1_q <= r1;
                        p2_q <= r2;
                    end
                end
                ST_INIT_Z: begin
                    if (mm_rdy) begin
                        z1_q <= r1;
                        z2_q <= r2;
                    end
                end
                ST_SQR: begin
                    if (mm_rdy) begin
                        z1_q  <= r1;
                        z2_q  <= r2;
                        e_q   <= e_q >> 1;
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_MERGE: result_q <= merged;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy   = (state_q != ST_IDLE) && (state_q != ST_DONE);
        done   = (state_q == ST_DONE);
        result = result_q;
    end

    // R2: busy and done never overlap
    p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R6: operands captured at launch are untouched by a start during a run
    p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(m_q) && $stable(base_q) && $stable(k_q)));

    // R7: the delivered value lies below the modulus
    p_result_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result < m_q));

    // R8: done and result hold until a new start
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(result)));
endmodule

// File: tb/sim_modexp_csa_seq.sv
`timescale 1ns/1ps
module sim_modexp_csa_seq;
    localparam int W     = 64;
    localparam int EXP_W = 64;
    localparam int RBITS = 2 * (W + 2);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [W-1:0]     base = '0;
    logic [EXP_W-1:0] expo = '0;
    logic [W-1:0]     modulus = 64'd3;
    logic [W-1:0]     mont_k = '0;
    logic             busy, done;
    logic [W-1:0]     result;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] exp_q [$];
    logic [W-1:0] mod_q [$];
    string        tag_q [$];
    logic [W-1:0] last_expect;

    always #2.5 clk = ~clk;

    modexp_csa_seq #(.W(W), .EXP_W(EXP_W)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .base    (base),
        .expo    (expo),
        .modulus (modulus),
        .mont_k  (mont_k),
        .busy    (busy),
        .done    (done),
        .result  (result)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [W-1:0] mulmod(input logic [W-1:0] a, input logic [W-1:0] b,
                                            input logic [W-1:0] m);
        logic [2*W-1:0] pr;
        pr = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        return W'(pr % {{W{1'b0}}, m});
    endfunction

    function automatic logic [W-1:0] ref_pow(input logic [W-1:0] b, input logic [EXP_W-1:0] e,
                                             input logic [W-1:0] m);
        logic [W-1:0] acc, sq;
        acc = W'(1) % m;
        sq  = b % m;
        for (int i = 0; i < EXP_W; i++) begin
            if (e[i]) acc = mulmod(acc, sq, m);
            sq = mulmod(sq, sq, m);
        end
        return acc;
    endfunction

    function automatic logic [W-1:0] kconst(input logic [W-1:0] m);
        logic [W:0] r;
        r = (W+1)'(1);
        for (int i = 0; i < RBITS; i++) r = (r << 1) % {1'b0, m};
        return W'(r);
    endfunction

    // driver: pushes the expected item, pulses start, waits for completion
    task automatic run_case(input logic [W-1:0] b, input logic [EXP_W-1:0] e,
                            input logic [W-1:0] m, input string tag, input bit poke);
        logic [W-1:0] expv;
        expv = ref_pow(b, e, m);
        exp_q.push_back(expv);
        mod_q.push_back(m);
        tag_q.push_back(tag);
        last_expect = expv;
        @(negedge clk);
        base = b; expo = e; modulus = m; mont_k = kconst(m); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1 && done === 1'b0, "R2 busy after start", {62'd0, busy, done}, 64'd2);
        if (poke) begin
            repeat (10) @(negedge clk);
            base = ~b; expo = ~e; modulus = 64'd5; mont_k = 64'd1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(busy === 1'b1 && done === 1'b0, "R6 busy kept after ignored start",
                {62'd0, busy, done}, 64'd2);
        end
        while (done !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor: pops and compares on each rising done
    logic done_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && done && !done_prev) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3 unexpected result", result, '0);
            end else begin
                logic [W-1:0] ev, mv;
                string        tg;
                ev = exp_q.pop_front();
                mv = mod_q.pop_front();
                tg = tag_q.pop_front();
                chk(result === ev, tg, result, ev);
                chk(result < mv, "R7 result below modulus", result, mv);
            end
        end
        done_prev <= done;
    end

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog expired", '0, '0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] m, b;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0, "R1 busy low in reset", {63'd0, busy}, '0);
        chk(done === 1'b0, "R1 done low in reset", {63'd0, done}, '0);
        chk(result === '0, "R1 result zero in reset", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1 idle after reset", {62'd0, busy, done}, '0);

        // R3: random odd moduli
        for (int n = 0; n < 5; n++) begin
            m = {$urandom(), $urandom()} | 64'h1;
            if (m < 64'd3) m = 64'd3;
            b = {$urandom(), $urandom()} % m;
            run_case(b, {$urandom(), $urandom()}, m, "R3 random power", 1'b0);
        end
        // R4: exponent zero
        m = 64'hF123_4567_89AB_CDEF;
        run_case(64'h1234_5678_9ABC_DEF0 % m, '0, m, "R4 exponent zero", 1'b0);
        // R5: exponent one, and zero base
        run_case(64'h0FED_CBA9_8765_4321, 64'd1, m, "R5 exponent one", 1'b0);
        run_case('0, 64'd1, m, "R5 zero base", 1'b0);
        // R9: all bits set, top bit only
        run_case(64'd7, '1, 64'hFFFF_FFFF_FFFF_FFC5, "R9 all-ones exponent", 1'b0);
        run_case(64'd3, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, "R9 top exponent bit", 1'b0);
        // smallest modulus
        run_case(64'd2, 64'd5, 64'd3, "R3 modulus three", 1'b0);
        // R6: start during a run is ignored
        run_case(64'd12345, 64'h0000_0000_0001_0001, 64'hC000_0000_0000_0007,
                 "R6 result unaffected", 1'b1);
        // R8: done and result hold
        repeat (20) @(negedge clk);
        chk(done === 1'b1, "R8 done held", {63'd0, done}, 64'd1);
        chk(result === last_expect, "R8 result held", result, last_expect);
        // R2: restart from done state clears done
        run_case(64'd9, 64'd2, 64'd101, "R2 restart from done", 1'b0);

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all results seen", 64'(exp_q.size()), '0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule